// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank DDR SDRAM. It takes one read or write request at a time from a client and turns it into a legal command stream on the chip select, row strobe, column strobe, write enable, bank-select, address and clock-enable pins. It keeps the open row of every bank, so an access to a row that is already open goes straight to the column command. An access to a closed bank is preceded by an ACTIVE. An access to a different row in an open bank is preceded by a PRECHARGE and an ACTIVE. Every command honours the bank timing, which is held as compile-time cycle counts.

A free-running interval timer raises a refresh demand. The demand wins over client requests. The sequencer closes all open rows with one precharge-all, issues AUTO REFRESH, and then holds off all traffic for the refresh recovery time. Out of reset it writes the mode register once, with the burst length and CAS latency chosen by parameters. Each request may ask for a self-timed row close after its burst. Because the device supports RAS lockout, such an access may follow its ACTIVE by only the activate-to-column delay. The data path, power-up waits and DLL reset belong elsewhere.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is held, cs_n, ras_n, cas_n and we_n are 1, cke is 0, and ba and addr are 0. The first command after reset is MODE REGISTER SET with ba=0. Its addr[2:0] holds the burst-length code (2→001, 4→010, 8→011), addr[3]=0, and addr[6:4] holds the CAS-latency code (2→010, 2.5→110, 3→011). All other bits are 0. cke rises in the same cycle.
- R2: Commands use cs_n=0 with {ras_n,cas_n,we_n}: NOP 111, ACTIVE 011, READ 101, WRITE 100, PRECHARGE 010, AUTO REFRESH 001, MODE REGISTER SET 000. Any cycle in which no command is due carries NOP with ba=0 and addr=0.
- R3: A request to a closed bank produces ACTIVE (ba = bank, addr = row). It is followed no sooner than T_RCD cycles later by READ or WRITE. That column command carries ba = bank, the column in addr[COL_W-1:0], addr[10] = the auto-precharge flag, and all other bits 0. req_ack is 1 in exactly the cycles in which a READ or WRITE is on the pins.
- R4: A request whose row is already open in its bank issues the column command with no ACTIVE. Column commands are spaced at least BURST_LEN/2 cycles after a READ and BURST_LEN/2+T_WR cycles after a WRITE.
- R5: A request to an open bank with a different row issues PRECHARGE for that bank (addr[10]=0). That PRECHARGE comes no sooner than T_RAS after the bank's ACTIVE and no sooner than the column spacing of R4. ACTIVE follows T_RP or more cycles later, and then the access.
- R6: A column command with auto precharge closes its row. The next request to that bank needs a new ACTIVE, no sooner than BURST_LEN/2+T_RP cycles after a READ or BURST_LEN/2+T_WR+T_RP cycles after a WRITE.
- R7: A refresh demand arises every T_REFI cycles after reset and takes priority over requests. Open rows are closed by PRECHARGE with addr[10]=1. AUTO REFRESH follows once every bank has been precharged for T_RP cycles. After it, no command other than NOP is issued for T_RFC cycles.
- R8: cke is 1 in every cycle after reset in which a command is on the pins.
- R9: Rows are tracked per bank. Opening a row in one bank leaves the rows open in other banks intact, and a later request to them is a hit.
- R10: After MODE REGISTER SET, no command other than NOP is issued for T_MRD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented; held until acknowledged |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the row after this burst |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_ack | output | 1 | Request served: its READ/WRITE is on the pins |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select |
| addr | output | ROW_W | Multiplexed row/column/mode address |

## Verification
A behavioural model built on absolute cycle stamps predicts every pin on every clock. Directed streams separate the three access paths to one bank: a closed bank, a row hit, and a row miss. A stream that opens several banks in turn shows whether rows are kept per bank. Write-then-read and auto-precharge sequences tell the read and write spacing apart from the row-close delay. Pseudo-random traffic over a small row set then keeps refresh demands landing mid-burst and with rows open, which drives the precharge-all path under varied residual timing.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

   typedef enum logic [2:0] {
      C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_PREA, C_REF, C_MRS
   } seq_cmd_e;

   // {ras_n, cas_n, we_n} for a selected device
   function automatic logic [2:0] strobe_code(seq_cmd_e c);
      case (c)
         C_ACT:         return 3'b011;
         C_RD:          return 3'b101;
         C_WR:          return 3'b100;
         C_PRE, C_PREA: return 3'b010;
         C_REF:         return 3'b001;
         C_MRS:         return 3'b000;
         default:       return 3'b111;
      endcase
   endfunction

   function automatic logic [2:0] burst_code(int bl);
      case (bl)
         2:       return 3'b001;
         4:       return 3'b010;
         default: return 3'b011;
      endcase
   endfunction

   // CAS latency given in half cycles
   function automatic logic [2:0] latency_code(int cl_x2);
      case (cl_x2)
         4:       return 3'b010;
         5:       return 3'b110;
         default: return 3'b011;
      endcase
   endfunction

endpackage

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
   parameter int ROW_W = 12,
   parameter int CNT_W = 6,
   parameter int T_RCD = 3,
   parameter int T_RAS = 6,
   parameter int T_RP  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             shut_i,
   input  logic             self_close_i,
   input  logic [CNT_W-1:0] self_wait_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             is_open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             col_ok_o,
   output logic             pre_ok_o,
   output logic             act_ok_o
);

   logic [CNT_W-1:0] rcd_q, ras_q, idle_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open_o <= 1'b0;
         row_o     <= '0;
         rcd_q     <= '0;
         ras_q     <= '0;
         idle_q    <= '0;
      end else begin
         if (open_i) begin
            is_open_o <= 1'b1;
            row_o     <= row_i;
            rcd_q     <= CNT_W'(T_RCD - 1);
            ras_q     <= CNT_W'(T_RAS - 1);
         end else begin
            if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
            if (ras_q != '0) ras_q <= ras_q - 1'b1;
         end
         if (shut_i) begin
            is_open_o <= 1'b0;
            idle_q    <= CNT_W'(T_RP - 1);
         end else if (self_close_i) begin
            is_open_o <= 1'b0;
            idle_q    <= self_wait_i;
         end else if (idle_q != '0) begin
            idle_q <= idle_q - 1'b1;
         end
      end
   end

   assign col_ok_o = (rcd_q == '0);
   assign pre_ok_o = (ras_q == '0);
   assign act_ok_o = !is_open_o && (idle_q == '0);

endmodule

// File: rtl/ddr_refresh_tick.sv
module ddr_refresh_tick #(
   parameter int T_REFI = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic served_i,
   output logic due_o
);

   localparam int TW = $clog2(T_REFI + 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         due_o <= 1'b0;
      end else if (cnt_q == TW'(T_REFI - 1)) begin
         cnt_q <= '0;
         due_o <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (served_i) due_o <= 1'b0;
      end
   end

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 9,
   parameter int BURST_LEN = 4,
   parameter int CAS_X2    = 5,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS     = 6,
   parameter int T_WR      = 2,
   parameter int T_RFC     = 10,
   parameter int T_MRD     = 2,
   parameter int T_REFI    = 1560,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_wr,
   input  logic             req_ap,
   input  logic [BA_W-1:0]  req_bank,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   output logic             req_ack,
   output logic             cke,
   output logic             cs_n,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [BA_W-1:0]  ba,
   output logic [ROW_W-1:0] addr
);
   import ddr_seq_pkg::*;

   localparam int RD_GAP   = BURST_LEN / 2;
   localparam int WR_GAP   = BURST_LEN / 2 + T_WR;
   localparam int RD_CLOSE = RD_GAP + T_RP;
   localparam int WR_CLOSE = WR_GAP + T_RP;
   localparam int CNT_W    = $clog2(T_RAS + T_RCD + WR_CLOSE + T_RFC + T_MRD + 1);
   localparam logic [ROW_W-1:0] MODE_WORD =
      ROW_W'({latency_code(CAS_X2), 1'b0, burst_code(BURST_LEN)});
   localparam logic [ROW_W-1:0] ALL_WORD = ROW_W'(1) << 10;

   initial begin : param_chk
      assert (NUM_BANKS == 4) else $error("bank count must be 4");
      assert (BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8) else $error("burst length");
      assert (CAS_X2 >= 4 && CAS_X2 <= 6) else $error("CAS latency");
      assert (ROW_W >= 11 && COL_W <= 10) else $error("address widths");
      assert (T_RCD >= 1 && T_RP >= 1 && T_RAS >= 1 && T_RFC >= 1 && T_MRD >= 1 && T_REFI >= 2)
         else $error("timing values");
   end

   logic [NUM_BANKS-1:0] open_v, col_ok_v, pre_ok_v, act_ok_v;
   logic [ROW_W-1:0]     row_v [NUM_BANKS];
   logic                 ref_due;
   logic                 mrs_done_q;
   logic [CNT_W-1:0]     blk_q, gap_q;
   seq_cmd_e             cmd;
   logic                 any_open, pre_all_ok, idle_all;
   logic [ROW_W-1:0]     col_word;

   // ---------------- per-bank state ----------------
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (req_bank == BA_W'(b));
      ddr_bank_slot #(
         .ROW_W(ROW_W), .CNT_W(CNT_W),
         .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)
      ) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .open_i       (cmd == C_ACT && sel),
         .shut_i       ((cmd == C_PRE && sel) || (cmd == C_PREA && open_v[b])),
         .self_close_i ((cmd == C_RD || cmd == C_WR) && req_ap && sel),
         .self_wait_i  (req_wr ? CNT_W'(WR_CLOSE - 1) : CNT_W'(RD_CLOSE - 1)),
         .row_i        (req_row),
         .is_open_o    (open_v[b]),
         .row_o        (row_v[b]),
         .col_ok_o     (col_ok_v[b]),
         .pre_ok_o     (pre_ok_v[b]),
         .act_ok_o     (act_ok_v[b])
      );
   end

   ddr_refresh_tick #(.T_REFI(T_REFI)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .served_i (cmd == C_REF),
      .due_o    (ref_due)
   );

   // ---------------- command choice ----------------
   always_comb begin
      any_open   = |open_v;
      pre_all_ok = (gap_q == '0);
      idle_all   = 1'b1;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (open_v[b] && !pre_ok_v[b]) pre_all_ok = 1'b0;
         if (!act_ok_v[b])              idle_all   = 1'b0;
      end
      cmd = C_NOP;
      if (!mrs_done_q) begin
         cmd = C_MRS;
      end else if (blk_q != '0) begin
         cmd = C_NOP;
      end else if (ref_due) begin
         if (any_open) begin
            if (pre_all_ok) cmd = C_PREA;
         end else if (idle_all) begin
            cmd = C_REF;
         end
      end else if (req_valid) begin
         if (open_v[req_bank]) begin
            if (row_v[req_bank] == req_row) begin
               if (col_ok_v[req_bank] && gap_q == '0) cmd = req_wr ? C_WR : C_RD;
            end else if (pre_ok_v[req_bank] && gap_q == '0) begin
               cmd = C_PRE;
            end
         end else if (act_ok_v[req_bank]) begin
            cmd = C_ACT;
         end
      end
   end

   always_comb begin
      col_word             = '0;
      col_word[COL_W-1:0]  = req_col;
      col_word[10]         = req_ap;
   end

   // ---------------- pin registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mrs_done_q <= 1'b0;
         blk_q      <= '0;
         gap_q      <= '0;
         req_ack    <= 1'b0;
         cke        <= 1'b0;
         cs_n       <= 1'b1;
         {ras_n, cas_n, we_n} <= 3'b111;
         ba         <= '0;
         addr       <= '0;
      end else begin
         cke     <= 1'b1;
         cs_n    <= 1'b0;
         {ras_n, cas_n, we_n} <= strobe_code(cmd);
         req_ack <= (cmd == C_RD || cmd == C_WR);
         ba      <= '0;
         addr    <= '0;
         case (cmd)
            C_MRS:       begin addr <= MODE_WORD; mrs_done_q <= 1'b1; end
            C_ACT:       begin ba <= req_bank; addr <= req_row; end
            C_RD, C_WR:  begin ba <= req_bank; addr <= col_word; end
            C_PRE:       ba   <= req_bank;
            C_PREA:      addr <= ALL_WORD;
            default:     ;
         endcase

         if (cmd == C_MRS)      blk_q <= CNT_W'(T_MRD - 1);
         else if (cmd == C_REF) blk_q <= CNT_W'(T_RFC - 1);
         else if (blk_q != '0)  blk_q <= blk_q - 1'b1;

         if (cmd == C_RD)       gap_q <= CNT_W'(RD_GAP - 1);
         else if (cmd == C_WR)  gap_q <= CNT_W'(WR_GAP - 1);
         else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
      end
   end

endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int BURST_LEN = 4,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS     = 6,
   parameter int T_WR      = 2,
   parameter int T_RFC     = 10,
   parameter int T_MRD     = 2,
   parameter int T_REFI    = 1560,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ack,
   input logic             cke,
   input logic             cs_n,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic [BA_W-1:0]  ba,
   input logic [ROW_W-1:0] addr
);

   localparam int LIMIT = T_REFI + T_RAS + BURST_LEN + T_WR + T_RP + T_RFC + T_MRD + 4;

   logic is_act, is_col, is_pre, is_ref, is_mrs, is_nop;
   assign is_act = !cs_n && {ras_n, cas_n, we_n} == 3'b011;
   assign is_col = !cs_n && !ras_n ? 1'b0 : (!cs_n && ras_n && !cas_n);
   assign is_pre = !cs_n && {ras_n, cas_n, we_n} == 3'b010;
   assign is_ref = !cs_n && {ras_n, cas_n, we_n} == 3'b001;
   assign is_mrs = !cs_n && {ras_n, cas_n, we_n} == 3'b000;
   assign is_nop = cs_n || {ras_n, cas_n, we_n} == 3'b111;

   logic [NUM_BANKS-1:0] open_q;
   int unsigned          since_act [NUM_BANKS];
   int unsigned          since_ref, since_mrs;
   logic                 mrs_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q    <= '0;
         since_ref <= 0;
         since_mrs <= 0;
         mrs_seen  <= 1'b0;
         for (int b = 0; b < NUM_BANKS; b++) since_act[b] <= 0;
      end else begin
         for (int b = 0; b < NUM_BANKS; b++)
            if (since_act[b] < 1000) since_act[b] <= since_act[b] + 1;
         if (is_act) begin
            open_q[ba]    <= 1'b1;
            since_act[ba] <= 1;
         end
         if (is_pre) begin
            if (addr[10]) open_q <= '0;
            else          open_q[ba] <= 1'b0;
         end
         if (is_col && addr[10]) open_q[ba] <= 1'b0;
         since_ref <= is_ref ? 1 : since_ref + 1;
         if (is_mrs) begin
            mrs_seen  <= 1'b1;
            since_mrs <= 1;
         end else if (since_mrs < 1000) begin
            since_mrs <= since_mrs + 1;
         end
      end
   end

   logic        cur_open;
   int unsigned cur_since;
   assign cur_open  = open_q[ba];
   assign cur_since = since_act[ba];

   assert_cke_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> cke);

   assert_ack_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> is_col);

   assert_col_after_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> (cur_open && cur_since >= T_RCD));

   assert_act_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> !cur_open);

   assert_pre_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && !addr[10] && cur_open) |-> cur_since >= T_RAS);

   assert_ref_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> (open_q == '0));

   assert_ref_deadline_R7: assert property (@(posedge clk) disable iff (!rst_n)
      since_ref <= LIMIT);

   assert_mrs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mrs_seen && !is_nop && !is_mrs) |-> since_mrs >= T_MRD);

endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(
   .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BURST_LEN(BURST_LEN),
   .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR),
   .T_RFC(T_RFC), .T_MRD(T_MRD), .T_REFI(T_REFI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .cke(cke), .cs_n(cs_n),
   .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
);

// File: tb/tb_ddr_cmd_seq.sv
module tb_ddr_cmd_seq;

   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 12;
   localparam int COL_W = 9;
   localparam int BL    = 4;
   localparam int CLX2  = 5;
   localparam int T_RCD = 3;
   localparam int T_RP  = 3;
   localparam int T_RAS = 6;
   localparam int T_WR  = 2;
   localparam int T_RFC = 10;
   localparam int T_MRD = 2;
   localparam int T_REFI = 250;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_wr = 1'b0, req_ap = 1'b0;
   logic [1:0] req_bank = '0;
   logic [ROW_W-1:0] req_row = '0;
   logic [COL_W-1:0] req_col = '0;
   logic req_ack, cke, cs_n, ras_n, cas_n, we_n;
   logic [1:0] ba;
   logic [ROW_W-1:0] addr;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ddr_cmd_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W), .BURST_LEN(BL), .CAS_X2(CLX2),
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR),
      .T_RFC(T_RFC), .T_MRD(T_MRD), .T_REFI(T_REFI)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
      .req_ap(req_ap), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_ack(req_ack), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr)
   );

   int total = 0, bad = 0;
   int cycles = 0;
   int n_req = 0, n_ack = 0, n_ref = 0;

   // ---------------- reference model (cycle stamps) ----------------
   int d = 0;
   bit pend = 0, mrs_done = 0, acted = 0;
   int blk_until = 0, gap_until = 0;
   bit b_open [4];
   int b_row  [4];
   int t_col  [4];
   int t_pre  [4];
   int t_act  [4];
   bit ap_shut[4];

   logic e_cs = 1, e_ras = 1, e_cas = 1, e_we = 1, e_cke = 0, e_ack = 0;
   logic [1:0] e_ba = '0;
   logic [ROW_W-1:0] e_addr = '0;
   string e_tag = "R1";

   function automatic logic [6:0] mode_expect();
      logic [2:0] blc, clc;
      blc = (BL == 2) ? 3'b001 : (BL == 4) ? 3'b010 : 3'b011;
      clc = (CLX2 == 4) ? 3'b010 : (CLX2 == 5) ? 3'b110 : 3'b011;
      return {clc, 1'b0, blc};
   endfunction

   task automatic set_pins(logic [2:0] s, logic [1:0] b, logic [ROW_W-1:0] a, string tag);
      e_cs = 1'b0; {e_ras, e_cas, e_we} = s; e_ba = b; e_addr = a; e_tag = tag;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         d = 0; pend = 0; mrs_done = 0; acted = 0; blk_until = 0; gap_until = 0;
         for (int b = 0; b < 4; b++) begin
            b_open[b] = 0; b_row[b] = 0; t_col[b] = 0; t_pre[b] = 0; t_act[b] = 0; ap_shut[b] = 0;
         end
         e_cs = 1; {e_ras, e_cas, e_we} = 3'b111; e_ba = 0; e_addr = 0; e_cke = 0; e_ack = 0;
         e_tag = "R1";
      end else begin
         int rb;
         bit any_open, all_pre, all_idle, fresh_blk;
         rb = int'(req_bank);
         e_cke = 1'b1; e_ack = 1'b0;
         fresh_blk = (mrs_done && d < blk_until && blk_until - d <= T_MRD && n_ref == 0);
         set_pins(3'b111, 2'd0, '0, fresh_blk ? "R10" : "R2");
         any_open = 0; all_pre = (d >= gap_until); all_idle = 1;
         for (int b = 0; b < 4; b++) begin
            if (b_open[b]) any_open = 1;
            if (b_open[b] && d < t_pre[b]) all_pre = 0;
            if (b_open[b] || d < t_act[b]) all_idle = 0;
         end
         if (!mrs_done) begin
            set_pins(3'b000, 2'd0, ROW_W'(mode_expect()), "R1");
            mrs_done = 1; blk_until = d + T_MRD;
         end else if (d < blk_until) begin
            // blocked: NOP
         end else if (pend) begin
            if (any_open) begin
               if (all_pre) begin
                  set_pins(3'b010, 2'd0, ROW_W'(1) << 10, "R7");
                  for (int b = 0; b < 4; b++)
                     if (b_open[b]) begin b_open[b] = 0; t_act[b] = d + T_RP; ap_shut[b] = 0; end
               end
            end else if (all_idle) begin
               set_pins(3'b001, 2'd0, '0, "R7");
               pend = 0; blk_until = d + T_RFC;
            end
         end else if (req_valid) begin
            if (b_open[rb]) begin
               if (b_row[rb] == int'(req_row)) begin
                  if (d >= t_col[rb] && d >= gap_until) begin
                     logic [ROW_W-1:0] cw;
                     int gap;
                     cw = '0; cw[COL_W-1:0] = req_col; cw[10] = req_ap;
                     set_pins(req_wr ? 3'b100 : 3'b101, req_bank, cw, acted ? "R3" : "R4");
                     e_ack = 1'b1; acted = 0;
                     gap = req_wr ? BL / 2 + T_WR : BL / 2;
                     gap_until = d + gap;
                     if (req_ap) begin
                        b_open[rb] = 0; t_act[rb] = d + gap + T_RP; ap_shut[rb] = 1;
                     end
                  end
               end else if (d >= t_pre[rb] && d >= gap_until) begin
                  set_pins(3'b010, req_bank, '0, "R5");
                  b_open[rb] = 0; t_act[rb] = d + T_RP; ap_shut[rb] = 0;
               end
            end else if (d >= t_act[rb]) begin
               string tg;
               tg = "R3";
               for (int b = 0; b < 4; b++) if (b_open[b]) tg = "R9";
               if (ap_shut[rb]) tg = "R6";
               set_pins(3'b011, req_bank, req_row, tg);
               b_open[rb] = 1; b_row[rb] = int'(req_row);
               t_col[rb] = d + T_RCD; t_pre[rb] = d + T_RAS; ap_shut[rb] = 0; acted = 1;
            end
         end
         if ((d + 1) % T_REFI == 0) pend = 1;
         d++;
      end
   end

   // ---------------- comparison on every clock ----------------
   always @(negedge clk) begin
      cycles++;
      total++;
      if ({cs_n, ras_n, cas_n, we_n, ba, addr, req_ack} !==
          {e_cs, e_ras, e_cas, e_we, e_ba, e_addr, e_ack}) begin
         bad++;
         $display("FAIL %s cyc=%0d got cs/ras/cas/we=%b%b%b%b ba=%0d addr=%h ack=%b exp %b%b%b%b ba=%0d addr=%h ack=%b",
                  e_tag, cycles, cs_n, ras_n, cas_n, we_n, ba, addr, req_ack,
                  e_cs, e_ras, e_cas, e_we, e_ba, e_addr, e_ack);
      end
      total++;
      if (cke !== e_cke) begin
         bad++;
         $display("FAIL R8 cyc=%0d cke got %b exp %b", cycles, cke, e_cke);
      end
      if (rst_n && req_ack) n_ack++;
      if (rst_n && !cs_n && {ras_n, cas_n, we_n} == 3'b001) n_ref++;
      if (cycles > WATCHDOG) begin
         bad++;
         $display("FAIL watchdog expired at cycle %0d", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic do_req(bit wr, bit ap, int bank, int row, int col);
      req_valid = 1'b1; req_wr = wr; req_ap = ap;
      req_bank = 2'(bank); req_row = ROW_W'(row); req_col = COL_W'(col);
      n_req++;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (req_ack) break;
      end
   endtask

   task automatic idle(int n);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [15:0] lf;
      repeat (3) @(negedge clk);          // reset state compared (R1)
      rst_n = 1'b1;
      idle(6);                            // MRS then T_MRD NOPs (R1, R10)
      do_req(0, 0, 0, 5, 3);              // closed bank: ACT then READ (R3)
      do_req(0, 0, 0, 5, 8);              // row hit (R4)
      do_req(1, 0, 0, 5, 12);             // write hit after read (R4)
      do_req(0, 0, 0, 5, 16);             // read after write spacing (R4)
      do_req(0, 0, 0, 9, 1);              // row miss: PRE, ACT, READ (R5)
      do_req(1, 1, 1, 3, 4);              // write with auto precharge (R3)
      do_req(0, 0, 1, 3, 6);              // reopen after self close (R6)
      do_req(0, 1, 1, 3, 2);              // read with auto precharge
      do_req(1, 0, 1, 3, 2);              // reopen after read close (R6)
      do_req(0, 0, 2, 7, 0);              // another bank (R9)
      do_req(0, 0, 3, 1, 0);
      do_req(1, 0, 2, 7, 5);              // hit in bank 2 kept (R9)
      do_req(0, 0, 0, 9, 9);              // bank 0 row still open (R9)
      idle(300);                          // refresh with rows open (R7)
      lf = 16'hACE1;
      for (int k = 0; k < 120; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         do_req(lf[0], lf[7] & lf[3], int'(lf[2:1]), int'(lf[5:4]), int'(lf[14:6]));
         if (lf[9] && lf[11]) idle(int'(lf[13:10]));
      end
      idle(20);
      total++;
      if (n_ack != n_req) begin
         bad++;
         $display("FAIL R3 ack count got %0d exp %0d", n_ack, n_req);
      end
      total++;
      if (n_ref < (cycles / T_REFI) - 1) begin
         bad++;
         $display("FAIL R7 refresh count got %0d exp >= %0d", n_ref, (cycles / T_REFI) - 1);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule